// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read a serial NOR flash as if it were ordinary memory. A bus master issues a read on a simple request/ready port. When memory-mapped mode is enabled, the engine turns that read into one complete flash read command. The selected flash device is kept selected for the whole command. The engine sends the programmed read opcode, then the word-aligned address, then the dummy clocks, and then collects four data bytes. The 32-bit result goes back to the master with a one-cycle ready pulse.

Each chip select has its own setup word. The setup word gives the opcode, the number of address bytes (1 to 4), the number of dummy bytes (0 to 3) and how many data lanes to use (1, 2 or 4). A switch register turns memory-mapped mode on or off and picks which chip select is used. While the mode is on, a flag tells a neighbouring command engine that it must not start operations. Switch writes are ignored while a read is pending or in progress.

The serial interface uses clock mode 0. The serial clock idles low, data is launched while the clock is low, and data is captured on the rising edge. One serial clock period lasts two system clocks.

Top module: `sflash_map_reader`

## Requirements
- R1: After reset, all chip selects are high (inactive), the serial clock is low, every output enable is 0, ready is 0 and the command-block flag is 0.
- R2: A configuration write to byte offset 0x54+4*n loads the setup word of chip select n. The fields are: opcode in bits 7:0, address bytes minus one in bits 9:8, dummy bytes in bits 11:10, and lane code in bits 13:12. Lane code 1 means two lanes, 3 means four lanes, and 0 or 2 means one lane.
- R3: A configuration write to offset 0x64 sets memory-mapped mode from bit 0 and the chip-select index from bits 5:4. The command-block output equals the stored mode bit.
- R4: A read is refused in two cases: memory-mapped mode is off, or the bus address is greater than or equal to the window size. A refused read sets ready and error together one cycle after acceptance, returns zero data, and produces no chip-select or serial clock activity.
- R5: A served read drives, on io[0] only and MSB first, the opcode followed by the address bytes of the word-aligned bus address, most significant byte first. Then it gives 8 serial clocks per dummy byte with every output enable at 0. The serial clock is low whenever no chip select is active.
- R6: The data phase samples io[1] in one-lane mode, io[1:0] in two-lane mode and io[3:0] in four-lane mode, with the higher pin index carrying the earlier bit. It takes 32, 16 or 8 serial clocks respectively.
- R7: The returned word is little-endian: bits 7:0 hold the first flash byte received, and bits 31:24 hold the fourth.
- R8: Exactly the selected chip select is driven low, and it stays low without a break from the first opcode bit to the last data bit.
- R9: Ready is a single-cycle pulse. For a served read it rises 2+2*N clock edges after acceptance, where N is the total number of serial clocks of the command.
- R10: A switch register write is ignored while a read is pending or in progress. The mode and chip-select index therefore stay stable across every transaction.
- R11: Each chip select uses only its own setup word, so differently programmed devices produce differently shaped commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| mm_rd | input | 1 | Bus read request, held until ready |
| mm_addr | input | ADDR_W | Bus byte address inside the window |
| mm_rdata | output | 32 | Read data, valid with ready |
| mm_ready | output | 1 | One-cycle completion pulse |
| mm_err | output | 1 | Read refused, valid with ready |
| cmd_blocked | output | 1 | Memory-mapped mode active; command engine must hold off |
| sclk | output | 1 | Serial flash clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_o | output | 4 | Serial data out |
| io_oe | output | 4 | Serial data output enables |
| io_i | input | 4 | Serial data in |

## Verification
The checker looks at every cycle. It verifies that at most one chip select is low, that the chip select does not change within a transaction, and that the serial clock and output enables stay quiet while no device is selected. It also verifies that ready is a single pulse, that a refused read carries zero data, and that the mode flag cannot change under an active chip select. The bench uses a behavioural flash model and sweeps every combination of chip select, address width, dummy count and lane code. Only these scenarios can show that the opcode and address bits appear in the right order, that the data lanes are assembled into the right little-endian word, and that the end-to-end latency matches the command length.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

   localparam logic [7:0] SETUP_BASE_OFS = 8'h54;
   localparam logic [7:0] SWITCH_OFS     = 8'h64;
   localparam int         SW_CS_LSB      = 4;
   localparam int         WORD_BYTES     = 4;
   localparam int         TX_W           = 40;
   localparam int         CNT_W          = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_TX,
      ST_DUM,
      ST_DAT,
      ST_DONE
   } sfm_state_e;

   typedef struct packed {
      logic [1:0] lane;
      logic [1:0] dummy;
      logic [1:0] abm1;
      logic [7:0] opcode;
   } sfm_setup_t;

   function automatic logic [CNT_W-1:0] data_clocks(input logic [1:0] lane);
      case (lane)
         2'd1:    data_clocks = CNT_W'(16);
         2'd3:    data_clocks = CNT_W'(8);
         default: data_clocks = CNT_W'(32);
      endcase
   endfunction

endpackage

// File: rtl/sfm_cfg_regs.sv
module sfm_cfg_regs
   import sfm_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int CSW    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [7:0]              cfg_addr,
   input  logic [31:0]             cfg_wdata,
   input  logic                    lock,
   output sfm_setup_t [NUM_CS-1:0] setup_o,
   output logic                    mm_en_o,
   output logic [CSW-1:0]          cs_sel_o
);

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
         localparam logic [7:0] OFS = SETUP_BASE_OFS + 8'(4 * g);
         sfm_setup_t r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r_q <= '0;
            else if (cfg_we && cfg_addr == OFS)
               r_q <= cfg_wdata[$bits(sfm_setup_t)-1:0];
         end
         assign setup_o[g] = r_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mm_en_o  <= 1'b0;
         cs_sel_o <= '0;
      end else if (cfg_we && cfg_addr == SWITCH_OFS && !lock) begin
         mm_en_o  <= cfg_wdata[0];
         cs_sel_o <= cfg_wdata[SW_CS_LSB +: CSW];
      end
   end

endmodule

// File: rtl/sfm_rx_pack.sv
module sfm_rx_pack
   import sfm_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    shift_en,
   input  logic [1:0]              lane,
   input  logic [3:0]              io_i,
   output logic [8*WORD_BYTES-1:0] word_o
);

   localparam int W = 8 * WORD_BYTES;

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else if (clr)
         sr_q <= '0;
      else if (shift_en) begin
         case (lane)
            2'd3:    sr_q <= {sr_q[W-5:0], io_i};
            2'd1:    sr_q <= {sr_q[W-3:0], io_i[1:0]};
            default: sr_q <= {sr_q[W-2:0], io_i[1]};
         endcase
      end
   end

   // first received byte sits at the top of the shifter; return it in the low byte
   generate
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_swap
         assign word_o[8*b +: 8] = sr_q[W-1-8*b -: 8];
      end
   endgenerate

endmodule

// File: rtl/sfm_seq.sv
module sfm_seq
   import sfm_pkg::*;
#(
   parameter int     NUM_CS    = 4,
   parameter int     CSW       = 2,
   parameter int     ADDR_W    = 24,
   parameter longint WIN_BYTES = 64'd1048576
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mm_rd,
   input  logic [ADDR_W-1:0]       mm_addr,
   input  logic                    mm_en,
   input  logic [CSW-1:0]          cs_sel,
   input  sfm_setup_t [NUM_CS-1:0] setup,
   output logic                    sclk,
   output logic [NUM_CS-1:0]       cs_n,
   output logic [3:0]              io_o,
   output logic [3:0]              io_oe,
   output logic                    rx_clr,
   output logic                    rx_shift,
   output logic [1:0]              rx_lane,
   output logic                    done,
   output logic                    done_err,
   output logic                    busy
);

   localparam logic [ADDR_W:0] WIN_L = (ADDR_W + 1)'(WIN_BYTES);

   sfm_state_e       st_q;
   logic             sclk_q;
   logic [CNT_W-1:0] cnt_q;
   logic [TX_W-1:0]  tx_q;
   logic [1:0]       lane_q;
   logic [1:0]       dum_q;
   logic [CSW-1:0]   cs_q;
   logic             err_q;

   sfm_setup_t  cur;
   logic        out_win;
   logic [31:0] faddr;
   logic [4:0]  sh;
   logic        active;

   assign cur     = setup[cs_sel];
   assign out_win = ({1'b0, mm_addr} >= WIN_L);
   assign faddr   = 32'({mm_addr[ADDR_W-1:2], 2'b00});
   assign sh      = {2'd3 - cur.abm1, 3'b000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sclk_q <= 1'b0;
         cnt_q  <= '0;
         tx_q   <= '0;
         lane_q <= '0;
         dum_q  <= '0;
         cs_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (mm_rd) begin
                  if (!mm_en || out_win) begin
                     st_q  <= ST_DONE;
                     err_q <= 1'b1;
                  end else begin
                     st_q   <= ST_SEL;
                     err_q  <= 1'b0;
                     cs_q   <= cs_sel;
                     lane_q <= cur.lane;
                     dum_q  <= cur.dummy;
                     tx_q   <= {cur.opcode, faddr << sh};
                     cnt_q  <= {3'(cur.abm1) + 3'd2, 3'b000};
                  end
               end
            end
            ST_SEL: st_q <= ST_TX;
            ST_TX, ST_DUM, ST_DAT: begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
               end else begin
                  sclk_q <= 1'b0;
                  if (st_q == ST_TX)
                     tx_q <= tx_q << 1;
                  if (cnt_q == CNT_W'(1)) begin
                     if (st_q == ST_TX && dum_q != 2'd0) begin
                        st_q  <= ST_DUM;
                        cnt_q <= {1'b0, dum_q, 3'b000};
                     end else if (st_q == ST_DAT) begin
                        st_q <= ST_DONE;
                     end else begin
                        st_q  <= ST_DAT;
                        cnt_q <= data_clocks(lane_q);
                     end
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign active = (st_q == ST_SEL) || (st_q == ST_TX) ||
                   (st_q == ST_DUM) || (st_q == ST_DAT);

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
         assign cs_n[g] = !(active && cs_q == CSW'(g));
      end
   endgenerate

   assign sclk     = sclk_q;
   assign io_o     = {3'b000, tx_q[TX_W-1]};
   assign io_oe    = {3'b000, (st_q == ST_SEL) || (st_q == ST_TX)};
   assign rx_clr   = (st_q == ST_SEL);
   assign rx_shift = (st_q == ST_DAT) && !sclk_q;
   assign rx_lane  = lane_q;
   assign done     = (st_q == ST_DONE);
   assign done_err = err_q;
   assign busy     = (st_q != ST_IDLE);

endmodule

// File: rtl/sflash_map_reader.sv
module sflash_map_reader
   import sfm_pkg::*;
#(
   parameter int     NUM_CS    = 4,
   parameter int     ADDR_W    = 24,
   parameter longint WIN_BYTES = 64'd1048576
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              mm_rd,
   input  logic [ADDR_W-1:0] mm_addr,
   output logic [31:0]       mm_rdata,
   output logic              mm_ready,
   output logic              mm_err,
   output logic              cmd_blocked,
   output logic              sclk,
   output logic [NUM_CS-1:0] cs_n,
   output logic [3:0]        io_o,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_i
);

   localparam int CSW = $clog2(NUM_CS);

   generate
      if (!(NUM_CS == 2 || NUM_CS == 4)) begin : g_bad_cs
         $error("NUM_CS must be 2 or 4");
      end
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must be within 3..32");
      end
      if (WIN_BYTES <= 0 || (WIN_BYTES % 4) != 0 || WIN_BYTES > (64'd1 << ADDR_W)) begin : g_bad_win
         $error("WIN_BYTES must be a positive multiple of 4 within the address range");
      end
   endgenerate

   sfm_setup_t [NUM_CS-1:0] setup;
   logic                    mm_en;
   logic [CSW-1:0]          cs_sel;
   logic                    busy;
   logic                    rx_clr;
   logic                    rx_shift;
   logic [1:0]              rx_lane;
   logic                    done;
   logic                    done_err;
   logic [31:0]             word;

   sfm_cfg_regs #(.NUM_CS(NUM_CS), .CSW(CSW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .lock      (busy || mm_rd),
      .setup_o   (setup),
      .mm_en_o   (mm_en),
      .cs_sel_o  (cs_sel)
   );

   sfm_seq #(.NUM_CS(NUM_CS), .CSW(CSW), .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mm_rd    (mm_rd),
      .mm_addr  (mm_addr),
      .mm_en    (mm_en),
      .cs_sel   (cs_sel),
      .setup    (setup),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .io_o     (io_o),
      .io_oe    (io_oe),
      .rx_clr   (rx_clr),
      .rx_shift (rx_shift),
      .rx_lane  (rx_lane),
      .done     (done),
      .done_err (done_err),
      .busy     (busy)
   );

   sfm_rx_pack u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rx_clr),
      .shift_en (rx_shift),
      .lane     (rx_lane),
      .io_i     (io_i),
      .word_o   (word)
   );

   assign mm_ready    = done;
   assign mm_err      = done && done_err;
   assign mm_rdata    = (done && !done_err) ? word : 32'd0;
   assign cmd_blocked = mm_en;

endmodule

// File: rtl/sflash_map_reader_chk.sv
module sflash_map_reader_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mm_ready,
   input logic              mm_err,
   input logic [31:0]       mm_rdata,
   input logic              cmd_blocked,
   input logic              sclk,
   input logic [NUM_CS-1:0] cs_n,
   input logic [3:0]        io_oe
);

   // R8
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R8
   cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&cs_n) && $past(!(&cs_n))) |-> $stable(cs_n));

   // R9
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mm_ready |=> !mm_ready);

   // R4
   refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_ready && mm_err) |-> (mm_rdata == 32'd0 && (&cs_n)));

   // R5
   idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk);

   // R5
   idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe != 4'b0000) |-> !(&cs_n));

   // R10
   mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&cs_n) |-> $stable(cmd_blocked));

endmodule

bind sflash_map_reader sflash_map_reader_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mm_ready    (mm_ready),
   .mm_err      (mm_err),
   .mm_rdata    (mm_rdata),
   .cmd_blocked (cmd_blocked),
   .sclk        (sclk),
   .cs_n        (cs_n),
   .io_oe       (io_oe)
);

// File: tb/sflash_map_reader_bench.sv
`timescale 1ns/1ps
module sflash_map_reader_bench;

   localparam int     NCS = 4;
   localparam int     AW  = 24;
   localparam longint WIN = 64'd1048576;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mm_rd = 1'b0;
   logic [AW-1:0] mm_addr = '0;
   logic [31:0] mm_rdata;
   logic        mm_ready, mm_err, cmd_blocked, sclk;
   logic [NCS-1:0] cs_n;
   logic [3:0]  io_o, io_oe;
   logic [3:0]  io_i = 4'b0000;

   always #2 clk = ~clk;

   sflash_map_reader #(.NUM_CS(NCS), .ADDR_W(AW), .WIN_BYTES(WIN)) u_sflash_map_reader (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .mm_rd(mm_rd), .mm_addr(mm_addr), .mm_rdata(mm_rdata), .mm_ready(mm_ready),
      .mm_err(mm_err), .cmd_blocked(cmd_blocked), .sclk(sclk), .cs_n(cs_n),
      .io_o(io_o), .io_oe(io_oe), .io_i(io_i));

   int total = 0;
   int fails = 0;

   // flash model state and the configuration it expects
   int          cur_ab = 3, cur_db = 0, cur_lanes = 1;
   int          edges = 0, oe_bad = 0, m_cs = -1;
   logic [7:0]  m_opc = '0;
   logic [31:0] m_addr = '0;

   function automatic logic [7:0] fbyte(input int cs, input logic [31:0] a);
      fbyte = 8'(a * 37) ^ 8'(cs * 91) ^ 8'h5a;
   endfunction

   function automatic logic fbit(input int k);
      logic [7:0] b;
      b = fbyte(m_cs, m_addr + 32'(k / 8));
      fbit = b[7 - (k % 8)];
   endfunction

   always @(posedge sclk) begin
      edges = edges + 1;
      if (edges <= 8)
         m_opc = {m_opc[6:0], io_o[0]};
      else if (edges <= 8 + 8 * cur_ab)
         m_addr = {m_addr[30:0], io_o[0]};
      if (edges <= 8 + 8 * cur_ab) begin
         if (io_oe != 4'b0001) oe_bad = oe_bad + 1;
      end else if (io_oe != 4'b0000) oe_bad = oe_bad + 1;
      for (int i = 0; i < NCS; i++)
         if (!cs_n[i]) m_cs = (m_cs == -1 || m_cs == i) ? i : -2;
      if (&cs_n) oe_bad = oe_bad + 1;
   end

   always @(negedge sclk) begin
      int g, k;
      g = edges - 8 - 8 * cur_ab - 8 * cur_db;
      k = g * cur_lanes;
      if (g >= 0 && k < 32 && m_cs >= 0) begin
         if (cur_lanes == 4)
            io_i = {fbit(k), fbit(k + 1), fbit(k + 2), fbit(k + 3)};
         else if (cur_lanes == 2)
            io_i = {2'b00, fbit(k), fbit(k + 1)};
         else
            io_i = {2'b00, fbit(k), 1'b0};
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total = total + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic model_arm(input int ab, input int db, input int lanes);
      cur_ab = ab; cur_db = db; cur_lanes = lanes;
      edges = 0; oe_bad = 0; m_cs = -1; m_opc = '0; m_addr = '0;
   endtask

   task automatic start_read(input logic [AW-1:0] a);
      @(negedge clk);
      mm_addr = a; mm_rd = 1'b1;
   endtask

   task automatic wait_ready(output int k, output logic [31:0] d, output logic e);
      k = 0;
      forever begin
         @(posedge clk);
         k = k + 1;
         @(negedge clk);
         if (mm_ready || k > 2000) break;
      end
      d = mm_rdata; e = mm_err;
      mm_rd = 1'b0;
      @(negedge clk);
      chk(!mm_ready, "R9", "ready single cycle", longint'(mm_ready), 0);
   endtask

   function automatic int lanes_of(input int code);
      lanes_of = (code == 1) ? 2 : (code == 3) ? 4 : 1;
   endfunction

   // full served read with every check on opcode, address, data, chip select and latency
   task automatic served_read(input int cs, input int abm1, input int db, input int lc,
                              input logic [7:0] opc, input logic [AW-1:0] a, input string tag);
      int k, ab, lanes, n;
      logic [31:0] d, al, expd;
      logic e;
      ab = abm1 + 1;
      lanes = lanes_of(lc);
      model_arm(ab, db, lanes);
      start_read(a);
      wait_ready(k, d, e);
      al = 32'({a[AW-1:2], 2'b00});
      if (ab < 4) al = al & ((32'd1 << (8 * ab)) - 32'd1);
      for (int j = 0; j < 4; j++) expd[8*j +: 8] = fbyte(cs, al + 32'(j));
      n = 8 + 8 * ab + 8 * db + 32 / lanes;
      chk(e == 1'b0, tag, "R4 served read flagged error", longint'(e), 0);
      chk(m_opc == opc, tag, "R5 opcode bits", longint'(m_opc), longint'(opc));
      chk(m_addr == al, tag, "R5 address bits", longint'(m_addr), longint'(al));
      chk(oe_bad == 0, tag, "R5 output enable per phase", oe_bad, 0);
      chk(edges == n, tag, "R6 serial clock count", edges, n);
      chk(d == expd, tag, "R7 little-endian word", longint'(d), longint'(expd));
      chk(m_cs == cs, tag, "R8 selected chip select", m_cs, cs);
      chk(k == 2 + 2 * n, tag, "R9 latency", k, 2 + 2 * n);
   endtask

   task automatic refused_read(input logic [AW-1:0] a, input string tag);
      int k;
      logic [31:0] d;
      logic e;
      model_arm(1, 0, 1);
      start_read(a);
      wait_ready(k, d, e);
      chk(e == 1'b1, tag, "R4 error flag", longint'(e), 1);
      chk(d == 32'd0, tag, "R4 zero data", longint'(d), 0);
      chk(edges == 0 && m_cs == -1, tag, "R4 no serial activity", edges, 0);
      chk(k == 1, tag, "R4 refusal latency", k, 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : main
      int k;
      logic [31:0] d;
      logic e;
      logic [AW-1:0] a;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_n == '1, "R1", "chip selects idle", longint'(cs_n), 15);
      chk(sclk == 1'b0 && io_oe == 4'b0000, "R1", "clock and enables", longint'({sclk, io_oe}), 0);
      chk(mm_ready == 1'b0 && cmd_blocked == 1'b0, "R1", "ready and block flag",
          longint'({mm_ready, cmd_blocked}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 mode off
      cfg_wr(8'h54, 32'h0000_0203);
      refused_read(24'h000100, "R4 mode off");
      // R3 mode on
      cfg_wr(8'h64, 32'h0000_0001);
      chk(cmd_blocked == 1'b1, "R3", "block flag on", longint'(cmd_blocked), 1);

      // R2 R5 R6 R7 R8 R9 sweep over chip select, address bytes, dummy bytes, lane code
      for (int c = 0; c < NCS; c++) begin
         for (int ab = 0; ab < 4; ab++) begin
            for (int db = 0; db < 4; db++) begin
               for (int lc = 0; lc < 4; lc++) begin
                  int idx;
                  logic [7:0] opc;
                  idx = c * 64 + ab * 16 + db * 4 + lc;
                  opc = 8'h0B ^ 8'(idx);
                  a = AW'((idx * 32'h2F3C4 + 32'h104) % 32'(WIN)) | AW'(idx & 3);
                  cfg_wr(8'h54 + 8'(4 * c), {18'd0, 2'(lc), 2'(db), 2'(ab), opc});
                  cfg_wr(8'h64, 32'(1 | (c << 4)));
                  served_read(c, ab, db, lc, opc, a, "R2 sweep");
               end
            end
         end
      end

      // R11 each chip select keeps its own setup
      cfg_wr(8'h54, {18'd0, 2'd3, 2'd1, 2'd2, 8'hEB});
      cfg_wr(8'h58, {18'd0, 2'd0, 2'd0, 2'd0, 8'h03});
      cfg_wr(8'h5C, {18'd0, 2'd1, 2'd2, 2'd3, 8'h3B});
      cfg_wr(8'h64, 32'h0000_0001);
      served_read(0, 2, 1, 3, 8'hEB, 24'h012344, "R11 cs0");
      cfg_wr(8'h64, 32'h0000_0011);
      served_read(1, 0, 0, 0, 8'h03, 24'h0000A8, "R11 cs1");
      cfg_wr(8'h64, 32'h0000_0021);
      served_read(2, 3, 2, 1, 8'h3B, 24'h0ABCD0, "R11 cs2");

      // R4 window boundary: last word inside, first address outside
      cfg_wr(8'h64, 32'h0000_0001);
      served_read(0, 2, 1, 3, 8'hEB, AW'(WIN - 1), "R4 last word");
      refused_read(AW'(WIN), "R4 window edge");

      // R10 switch write during a transaction is ignored
      model_arm(3, 1, 4);
      start_read(24'h012344);
      repeat (10) @(negedge clk);
      cfg_wdata = 32'h0000_0010; cfg_addr = 8'h64; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      wait_ready(k, d, e);
      chk(e == 1'b0 && m_cs == 0, "R10", "mid-read switch write", m_cs, 0);
      chk(cmd_blocked == 1'b1, "R10", "mode kept after ignored write", longint'(cmd_blocked), 1);
      served_read(0, 2, 1, 3, 8'hEB, 24'h000040, "R10 follow-up");

      // R3 mode off again
      cfg_wr(8'h64, 32'h0000_0000);
      chk(cmd_blocked == 1'b0, "R3", "block flag off", longint'(cmd_blocked), 0);
      refused_read(24'h000040, "R3 after mode off");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule